// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block holds the single memory reservation of one processor so that the processor can build atomic read-modify-write sequences out of a reserving load and a conditional store. A reserving load records the byte address that the load used and arms the reservation. From then on the block watches a snoop port that carries writes from other agents. The reservation is dropped when one of those writes lands anywhere in the same aligned 32-byte granule.

A conditional store asks whether its write may go out. The block answers one cycle later with a one-cycle valid pulse. The answer carries a pass flag, a write-enable for the memory side and a four-bit condition nibble. The store passes only while the reservation is armed and its word address equals the word address of the latest reserving load. Every conditional store disarms the reservation, whether it passes or fails. There is also a clear input that drops the reservation. Interrupts and traps have no path into the block, so they leave a reservation in place.

The reservation is a two-state machine. In state RSV_EMPTY no reservation is held, and in state RSV_HELD one is held. These are the transitions:
- LOAD: a reserving load moves either state to RSV_HELD.
- DROP: a conditional store, a snoop hit or a clear moves RSV_HELD to RSV_EMPTY.
- IDLE: in every other case the state stays as it is.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, `rsv_valid` is 0 and `sc_valid`, `sc_pass`, `sc_write_go` and `sc_cond` are all 0.
- R2: A reserving load (`lr_req`=1) makes `rsv_valid` 1 from the next cycle on and records `lr_addr`.
- R3: A conditional store passes only if the reservation was held in its request cycle and the store address matches the recorded address in bits [31:2]. In every other case it fails. This includes a store to a different word while the reservation is held. `sc_write_go` always equals `sc_pass`.
- R4: `sc_cond` is laid out as bit 3 = lt, bit 2 = gt, bit 1 = eq, bit 0 = so. When a result is reported, lt and gt are 0, eq equals the pass flag, and so equals `so_in` as sampled in the request cycle.
- R5: Every conditional store drops the reservation, whether it passes or fails.
- R6: A conditional store requested in cycle N raises `sc_valid` for exactly cycle N+1. In any cycle without a result, `sc_valid`, `sc_pass`, `sc_write_go` and `sc_cond` are all 0.
- R7: A snooped write (`snoop_wr`=1) drops a held reservation when `snoop_addr[31:5]` equals the recorded address bits [31:5]. A snooped write to any other granule leaves the reservation held.
- R8: A reserving load in the same cycle as a snoop hit, a clear or a conditional store wins. The reservation is held afterwards with the new address. A store in that same cycle is still judged against the state held before that cycle.
- R9: `clr_req`=1 drops the reservation.
- R10: A second reserving load with no store in between replaces the recorded address. A later store to the first address fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Reserving load request |
| lr_addr | input | 32 | Byte address of the reserving load |
| sc_req | input | 1 | Conditional store request |
| sc_addr | input | 32 | Byte address of the conditional store |
| so_in | input | 1 | Summary-overflow bit copied into the result |
| snoop_wr | input | 1 | A write by another agent is observed |
| snoop_addr | input | 32 | Byte address of the observed write |
| clr_req | input | 1 | Drops the reservation |
| rsv_valid | output | 1 | The reservation is held |
| sc_valid | output | 1 | One-cycle pulse marking a store result |
| sc_pass | output | 1 | The conditional store succeeded |
| sc_write_go | output | 1 | The memory side may perform the write |
| sc_cond | output | 4 | Condition nibble {lt, gt, eq, so} |

## Verification
Reservation changes show on `rsv_valid` after the one clock edge that samples the request. The store result shows on `sc_valid`, `sc_pass`, `sc_write_go` and `sc_cond` after that same edge, because each is a single register stage. The bench therefore drives each step on a falling edge, waits for the next rising edge and samples 1 ns after it, before the next drive. Checks on the reservation state and on the store result are thus made in the same step as the request that caused them. The pulse width of the result is checked in the step that follows.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [0:0] {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_nib_t;

endpackage

// File: rtl/lrsc_granule_cmp.sv
module lrsc_granule_cmp #(
    parameter int ADDR_W = 32,
    parameter int LSB    = 5
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << LSB) - ADDR_W'(1));

    always_comb begin
        hit = ~|((addr_a ^ addr_b) & MASK);
    end
endmodule

// File: rtl/lrsc_rsv_fsm.sv
module lrsc_rsv_fsm
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_evt,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              drop_evt,
    output rsv_state_e        state,
    output logic [ADDR_W-1:0] held_addr
);
    rsv_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RSV_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // next state: LOAD beats DROP, else IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            RSV_EMPTY: begin
                if (load_evt) state_nx = RSV_HELD;
            end
            RSV_HELD: begin
                if (load_evt)      state_nx = RSV_HELD;
                else if (drop_evt) state_nx = RSV_EMPTY;
            end
            default: state_nx = RSV_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
        end else if (load_evt) begin
            held_addr <= load_addr;
        end
    end
endmodule

// File: rtl/lrsc_sc_resp.sv
module lrsc_sc_resp
    import lrsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sc_req,
    input  logic    held,
    input  logic    word_hit,
    input  logic    so_in,
    output logic    res_valid,
    output logic    res_pass,
    output logic    res_write,
    output cr_nib_t res_cond
);
    logic    pass_nx;
    cr_nib_t cond_nx;

    always_comb begin
        pass_nx    = sc_req & held & word_hit;
        cond_nx    = '0;
        cond_nx.eq = pass_nx;
        cond_nx.so = sc_req & so_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_write <= 1'b0;
            res_cond  <= '0;
        end else begin
            res_valid <= sc_req;
            res_pass  <= pass_nx;
            res_write <= pass_nx;
            res_cond  <= cond_nx;
        end
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_req,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              so_in,
    input  logic              snoop_wr,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clr_req,
    output logic              rsv_valid,
    output logic              sc_valid,
    output logic              sc_pass,
    output logic              sc_write_go,
    output logic [3:0]        sc_cond
);
    localparam int GRAN_LSB = $clog2(GRAN_BYTES);
    localparam int WORD_LSB = $clog2(WORD_BYTES);

    rsv_state_e        rsv_state;
    logic [ADDR_W-1:0] rsv_addr_q;
    logic              held;
    logic              snoop_hit;
    logic              word_hit;
    logic              drop_evt;
    cr_nib_t           cond_q;

    lrsc_granule_cmp #(.ADDR_W(ADDR_W), .LSB(GRAN_LSB)) u_snoop_cmp (
        .addr_a (snoop_addr),
        .addr_b (rsv_addr_q),
        .hit    (snoop_hit)
    );

    lrsc_granule_cmp #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_word_cmp (
        .addr_a (sc_addr),
        .addr_b (rsv_addr_q),
        .hit    (word_hit)
    );

    always_comb begin
        held     = (rsv_state == RSV_HELD);
        drop_evt = sc_req | clr_req | (snoop_wr & snoop_hit);
    end

    lrsc_rsv_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_evt  (lr_req),
        .load_addr (lr_addr),
        .drop_evt  (drop_evt),
        .state     (rsv_state),
        .held_addr (rsv_addr_q)
    );

    lrsc_sc_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_req    (sc_req),
        .held      (held),
        .word_hit  (word_hit),
        .so_in     (so_in),
        .res_valid (sc_valid),
        .res_pass  (sc_pass),
        .res_write (sc_write_go),
        .res_cond  (cond_q)
    );

    // output process
    always_comb begin
        rsv_valid = held;
        sc_cond   = cond_q;
    end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lr_req,
    input logic              sc_req,
    input logic              snoop_wr,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              clr_req,
    input logic              rsv_valid,
    input logic [ADDR_W-1:0] rsv_addr,
    input logic              sc_valid,
    input logic              sc_pass,
    input logic              sc_write_go,
    input logic [3:0]        sc_cond
);
    localparam logic [ADDR_W-1:0] GMASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));
    logic snp_same;
    always_comb snp_same = ~|((snoop_addr ^ rsv_addr) & GMASK);

    a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        lr_req |=> rsv_valid);
    a_r3_write_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        sc_write_go |-> $past(rsv_valid));
    a_r3_write_eq_pass: assert property (@(posedge clk) disable iff (!rst_n)
        sc_write_go == sc_pass);
    a_r4_lt_gt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |-> (sc_cond[3:2] == 2'b00 && sc_cond[1] == sc_pass));
    a_r5_sc_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !lr_req) |=> !rsv_valid);
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> sc_valid);
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> (!sc_valid && !sc_pass && sc_cond == 4'h0));
    a_r7_snoop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_wr && snp_same && rsv_valid && !lr_req) |=> !rsv_valid);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !lr_req) |=> !rsv_valid);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lr_req      (lr_req),
    .sc_req      (sc_req),
    .snoop_wr    (snoop_wr),
    .snoop_addr  (snoop_addr),
    .clr_req     (clr_req),
    .rsv_valid   (rsv_valid),
    .rsv_addr    (rsv_addr_q),
    .sc_valid    (sc_valid),
    .sc_pass     (sc_pass),
    .sc_write_go (sc_write_go),
    .sc_cond     (sc_cond)
);

// File: tb/lrsc_monitor_test.sv
module lrsc_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] A  = 32'h1000_0040;
    localparam logic [31:0] B  = 32'h2000_0000;

    typedef struct packed {
        logic        lr;
        logic [31:0] la;
        logic        sc;
        logic [31:0] sa;
        logic        so;
        logic        sn;
        logic [31:0] na;
        logic        clr;
        logic        e_rsv;
        logic        e_scv;
        logic        e_pass;
        logic [3:0]  e_cond;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd2},  // R2 arm
        '{1'b0, 32'h0, 1'b1, A, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h3, 8'd4},  // R4 pass, so=1
        '{1'b0, 32'h0, 1'b1, A, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd3},  // R3 no rsv
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd6},  // R6 pulse ends
        '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, A + 32'h1C, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd7}, // R7 same granule
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd2},
        '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, A + 32'h20, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd7}, // R7 other granule
        '{1'b0, 32'h0, 1'b1, A, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h3, 8'd5},  // R5 pass drops
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd2},
        '{1'b0, 32'h0, 1'b1, A + 32'h4, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd3}, // R3 other word
        '{1'b0, 32'h0, 1'b1, A, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h1, 8'd5},  // R5 fail dropped it
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd2},
        '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd9},  // R9 clear
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b1, A, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd8},      // R8 lr beats snoop
        '{1'b1, B, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd10}, // R10 replace
        '{1'b0, 32'h0, 1'b1, A, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd10}, // R10 old addr fails
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd2},
        '{1'b1, A, 1'b1, A, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h2, 8'd8},      // R8 lr beats sc
        '{1'b0, 32'h0, 1'b1, A, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h2, 8'd5},
        '{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'd8},  // R8 lr beats clr
        '{1'b0, 32'h0, 1'b1, A + 32'h2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h2, 8'd3} // R3 byte in word
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lr_req = 1'b0, sc_req = 1'b0, so_in = 1'b0, snoop_wr = 1'b0, clr_req = 1'b0;
    logic [31:0] lr_addr = '0, sc_addr = '0, snoop_addr = '0;
    logic        rsv_valid, sc_valid, sc_pass, sc_write_go;
    logic [3:0]  sc_cond;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsc_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .lr_req(lr_req), .lr_addr(lr_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .so_in(so_in),
        .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
        .clr_req(clr_req),
        .rsv_valid(rsv_valid), .sc_valid(sc_valid), .sc_pass(sc_pass),
        .sc_write_go(sc_write_go), .sc_cond(sc_cond)
    );

    task automatic check(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        lr_req = v.lr; lr_addr = v.la; sc_req = v.sc; sc_addr = v.sa; so_in = v.so;
        snoop_wr = v.sn; snoop_addr = v.na; clr_req = v.clr;
        @(posedge clk);
        #1;
        check("rsv_valid", int'(v.req), 32'(rsv_valid), 32'(v.e_rsv));
        check("sc_valid", int'(v.req), 32'(sc_valid), 32'(v.e_scv));
        check("sc_pass", int'(v.req), 32'(sc_pass), 32'(v.e_pass));
        check("sc_write_go", int'(v.req), 32'(sc_write_go), 32'(v.e_pass));
        check("sc_cond", int'(v.req), 32'(sc_cond), 32'(v.e_cond));
    endtask

    localparam vec_t IDLE = '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd6};

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("reset rsv_valid", 1, 32'(rsv_valid), 32'h0);
        check("reset sc_valid", 1, 32'(sc_valid), 32'h0);
        check("reset sc_cond", 1, 32'(sc_cond), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) step(VEC[i]);
        // R6: result stays one cycle only
        step(IDLE);
        // R1: reset while reservation held
        step('{1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd2});
        @(negedge clk);
        rst_n = 1'b0;
        lr_req = 1'b0;
        @(posedge clk);
        #1;
        check("mid reset rsv_valid", 1, 32'(rsv_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: store after reset fails
        step('{1'b0, 32'h0, 1'b1, A, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd3});
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule